// File: doc/BRIEF.md
# Full-Speed USB Line Transceiver Control Core

This block is the digital core that sits between a logic-side serial interface and the D+/D- line state of a full-speed USB front end. In transmit direction it turns the logic-side inputs into D+/D- drive values and a drive enable. In receive direction it decodes the sampled line levels into the logic-side outputs, together with an enable for those outputs. Line levels arrive as resolved bits. They pass through a synchronizer before any decoding.

A parameter picks one of two interface styles. The three-wire style carries a data bit and a single-ended-zero bit. The five-wire style carries a D+ bit, a D- bit and a separate differential-receive output. Two power flags, one for the bus supply and one for the logic supply, select one of three states: normal operation, a sharing state in which the lines are released to other circuitry, and a disabled state. A suspend input turns off the differential receiver. An enumerate input controls the D+ pullup.

Top module: `fs_line_xcvr`

## Requirements
- R1: In normal power (vbus_ok=1, vlog_ok=1), after direction settles, oe_req=0 gives line_drv_en=1 with if_drv_en=0, and oe_req=1 gives if_drv_en=1 with line_drv_en=0. dp_out and dm_out read 0 whenever line_drv_en=0.
- R2: Three-wire style (WIRE5=0) while driving: ifb_in=1 gives dp_out=0 and dm_out=0 whatever ifa_in is. With ifb_in=0, dp_out=ifa_in and dm_out=~ifa_in.
- R3: Five-wire style (WIRE5=1) while driving: dp_out=ifa_in and dm_out=ifb_in, so two zeros give a single-ended zero.
- R4: The line inputs reach the decoder two clock edges after they are sampled, and the synchronizer resets to idle (D+=1, D-=0). The differential value is 1 for D+=1/D-=0 and 0 for D+=0/D-=1. For both-low or both-high it keeps the last decoded value, which resets to 1.
- R5: With susp_req=1, rcv_out reads 0 and the held differential value stays frozen. Transmit still follows R2/R3.
- R6: Three-wire receive: ifa_out is the differential value when susp_req=0 and the synchronized D+ level when susp_req=1. ifb_out is 1 exactly when both synchronized lines are 0.
- R7: Five-wire receive: ifa_out and ifb_out equal the synchronized D+ and D- levels. rcv_out is the differential value in normal power with susp_req=0, whatever oe_req is.
- R8: pullup_on = enum_req in normal power, else 0.
- R9: Sharing (vlog_ok=1, vbus_ok=0): line_drv_en, if_drv_en, bus_det and rcv_out are 0 whatever oe_req and susp_req are.
- R10: Disabled (vbus_ok=1, vlog_ok=0) and unpowered: line_drv_en and if_drv_en are 0. When an interface output is not enabled, it reads 1 in the five-wire style with vbus_ok=0, and 0 otherwise.
- R11: bus_det is 1 only in the three-wire style in normal power.
- R12: A change of oe_req seen at a clock edge makes both enables 0 for exactly the cycle after that edge. The two enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_req | input | 1 | Direction request: 0 transmit, 1 receive |
| susp_req | input | 1 | Suspend request |
| enum_req | input | 1 | Enumerate request for the D+ pullup |
| vbus_ok | input | 1 | Bus supply present |
| vlog_ok | input | 1 | Logic supply present |
| dp_in | input | 1 | Sampled D+ level |
| dm_in | input | 1 | Sampled D- level |
| ifa_in | input | 1 | Interface input A: data (3-wire) or D+ value (5-wire) |
| ifb_in | input | 1 | Interface input B: single-ended zero (3-wire) or D- value (5-wire) |
| dp_out | output | 1 | D+ drive value |
| dm_out | output | 1 | D- drive value |
| line_drv_en | output | 1 | D+/D- drive enable |
| pullup_on | output | 1 | D+ pullup connect |
| ifa_out | output | 1 | Interface output A |
| ifb_out | output | 1 | Interface output B |
| if_drv_en | output | 1 | Interface output enable |
| rcv_out | output | 1 | Differential receive output (5-wire style) |
| bus_det | output | 1 | Bus supply detect (3-wire style) |

## Verification
The only hidden state is the two-stage line synchronizer, the held differential value and the direction register with its turnaround flag. A wrong held value shows up at the first both-low or both-high line state after the error, on rcv_out or on the three-wire data output. A wrong synchronizer shows up as a shift of receive outputs by one or more cycles on any line transition. A wrong direction register shows up in the same cycle as a missing or extra turnaround cycle on the two enables. A reference model updated each clock predicts every output in every cycle for both interface styles, so any of these errors is caught within about two cycles of the stimulus that exposes it.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  typedef struct packed {
    logic dp;
    logic dm;
  } line_t;

  localparam line_t LINE_IDLE_J = '{dp: 1'b1, dm: 1'b0};

  typedef enum logic [1:0] {
    PWR_OFF     = 2'd0,
    PWR_DISABLE = 2'd1,
    PWR_SHARE   = 2'd2,
    PWR_NORMAL  = 2'd3
  } pwr_t;

  function automatic pwr_t pwr_mode(input logic vbus, input logic vlog);
    case ({vbus, vlog})
      2'b11:   return PWR_NORMAL;
      2'b01:   return PWR_SHARE;
      2'b10:   return PWR_DISABLE;
      default: return PWR_OFF;
    endcase
  endfunction

  // Three-wire encoding: single-ended zero wins over data.
  function automatic line_t tx_three(input logic dat, input logic se0);
    line_t l;
    l.dp = ~se0 & dat;
    l.dm = ~se0 & ~dat;
    return l;
  endfunction

  // Differential decision with hold on both-low / both-high.
  function automatic logic diff_next(input line_t l, input logic prev);
    case ({l.dp, l.dm})
      2'b10:   return 1'b1;
      2'b01:   return 1'b0;
      default: return prev;
    endcase
  endfunction

endpackage

// File: rtl/fsl_sync.sv
module fsl_sync
  import fsl_pkg::*;
#(
  parameter int    STAGES  = 2,
  parameter line_t RST_VAL = LINE_IDLE_J
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_t d,
  output line_t q
);
  localparam int LAST = STAGES - 1;

  line_t stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= RST_VAL;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[LAST];
endmodule

// File: rtl/fsl_dir_ctl.sv
module fsl_dir_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_req,
  input  logic normal,
  output logic drv_line,
  output logic drv_if
);
  logic oe_q;
  logic gap_q;
  logic turn;

  assign turn = (oe_req != oe_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b1;
      gap_q <= 1'b0;
    end else begin
      oe_q  <= oe_req;
      gap_q <= turn;
    end
  end

  assign drv_line = normal & ~oe_q & ~gap_q;
  assign drv_if   = normal &  oe_q & ~gap_q;

  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_line && drv_if));

  p_gap_after_turn_r12: assert property (@(posedge clk) disable iff (!rst_n)
    turn |=> (!drv_line && !drv_if));

  p_settled_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && !oe_req && !turn && !gap_q) |-> drv_line);
endmodule

// File: rtl/fsl_rx_decode.sv
module fsl_rx_decode
  import fsl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  susp,
  input  line_t ls,
  output logic  held
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= 1'b1;
    else if (!susp) last_q <= diff_next(ls, last_q);
  end

  assign held = diff_next(ls, last_q);

  p_j_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp && ls.dp && !ls.dm) |=> last_q);

  p_k_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp && !ls.dp && ls.dm) |=> !last_q);

  p_frozen_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> $stable(last_q));
endmodule

// File: rtl/fs_line_xcvr.sv
module fs_line_xcvr
  import fsl_pkg::*;
#(
  parameter bit WIRE5       = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_req,
  input  logic susp_req,
  input  logic enum_req,
  input  logic vbus_ok,
  input  logic vlog_ok,
  input  logic dp_in,
  input  logic dm_in,
  input  logic ifa_in,
  input  logic ifb_in,
  output logic dp_out,
  output logic dm_out,
  output logic line_drv_en,
  output logic pullup_on,
  output logic ifa_out,
  output logic ifb_out,
  output logic if_drv_en,
  output logic rcv_out,
  output logic bus_det
);
  pwr_t  pwr;
  logic  normal;
  logic  sharing;
  logic  drv_line, drv_if;
  line_t raw_line, ls, tx_line;
  logic  held;
  logic  rx_a, rx_b;
  logic  idle_level;

  assign pwr      = pwr_mode(vbus_ok, vlog_ok);
  assign normal   = (pwr == PWR_NORMAL);
  assign sharing  = (pwr == PWR_SHARE);
  assign raw_line = '{dp: dp_in, dm: dm_in};

  fsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE_J)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_line), .q(ls)
  );

  fsl_dir_ctl u_dir (
    .clk(clk), .rst_n(rst_n), .oe_req(oe_req), .normal(normal),
    .drv_line(drv_line), .drv_if(drv_if)
  );

  fsl_rx_decode u_rx (
    .clk(clk), .rst_n(rst_n), .susp(susp_req), .ls(ls), .held(held)
  );

  if (WIRE5) begin : g_five
    assign tx_line    = '{dp: ifa_in, dm: ifb_in};
    assign rx_a       = ls.dp;
    assign rx_b       = ls.dm;
    assign idle_level = ~vbus_ok;
    assign rcv_out    = normal & ~susp_req & held;
    assign bus_det    = 1'b0;

    p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      if_drv_en |-> (ifa_out == ls.dp && ifb_out == ls.dm));
  end else begin : g_three
    assign tx_line    = tx_three(ifa_in, ifb_in);
    assign rx_a       = susp_req ? ls.dp : held;
    assign rx_b       = ~ls.dp & ~ls.dm;
    assign idle_level = 1'b0;
    assign rcv_out    = 1'b0;
    assign bus_det    = normal;

    p_se0_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_drv_en && ifb_in) |-> (!dp_out && !dm_out));
  end

  assign line_drv_en = drv_line;
  assign if_drv_en   = drv_if;
  assign dp_out      = drv_line & tx_line.dp;
  assign dm_out      = drv_line & tx_line.dm;
  assign ifa_out     = drv_if ? rx_a : idle_level;
  assign ifb_out     = drv_if ? rx_b : idle_level;
  assign pullup_on   = normal & enum_req;

  p_sharing_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sharing |-> (!line_drv_en && !if_drv_en && !bus_det && !rcv_out));

  p_unpowered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vlog_ok |-> (!line_drv_en && !if_drv_en));

  p_rcv_low_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> !rcv_out);

  p_pullup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_on |-> (enum_req && vbus_ok && vlog_ok));
endmodule

// File: tb/sim_fs_line_xcvr.sv
module sim_fs_line_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_req = 1'b1, susp_req = 1'b0, enum_req = 1'b0;
  logic vbus_ok = 1'b1, vlog_ok = 1'b1;
  logic dp_in = 1'b1, dm_in = 1'b0, ifa_in = 1'b0, ifb_in = 1'b0;

  logic [1:0] dp_o, dm_o, lde, pu, ia, ib, ide, rc, bd;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fs_line_xcvr #(.WIRE5(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .oe_req(oe_req), .susp_req(susp_req),
    .enum_req(enum_req), .vbus_ok(vbus_ok), .vlog_ok(vlog_ok),
    .dp_in(dp_in), .dm_in(dm_in), .ifa_in(ifa_in), .ifb_in(ifb_in),
    .dp_out(dp_o[0]), .dm_out(dm_o[0]), .line_drv_en(lde[0]), .pullup_on(pu[0]),
    .ifa_out(ia[0]), .ifb_out(ib[0]), .if_drv_en(ide[0]), .rcv_out(rc[0]),
    .bus_det(bd[0])
  );

  fs_line_xcvr #(.WIRE5(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .oe_req(oe_req), .susp_req(susp_req),
    .enum_req(enum_req), .vbus_ok(vbus_ok), .vlog_ok(vlog_ok),
    .dp_in(dp_in), .dm_in(dm_in), .ifa_in(ifa_in), .ifb_in(ifb_in),
    .dp_out(dp_o[1]), .dm_out(dm_o[1]), .line_drv_en(lde[1]), .pullup_on(pu[1]),
    .ifa_out(ia[1]), .ifb_out(ib[1]), .if_drv_en(ide[1]), .rcv_out(rc[1]),
    .bus_det(bd[1])
  );

  // Reference model state: line history, held differential value, direction.
  logic [1:0] hist[$] = '{2'b10, 2'b10};
  logic m_last = 1'b1;
  logic m_oe = 1'b1;
  logic m_gap = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      hist = '{2'b10, 2'b10};
      m_last = 1'b1;
      m_oe = 1'b1;
      m_gap = 1'b0;
    end else begin
      if (!susp_req) begin
        if (hist[0] == 2'b10) m_last = 1'b1;
        else if (hist[0] == 2'b01) m_last = 1'b0;
      end
      hist.push_back({dp_in, dm_in});
      void'(hist.pop_front());
      m_gap = (oe_req != m_oe);
      m_oe = oe_req;
    end
  end

  task automatic chk(string req, string nm, int w, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s (style %0d) t=%0t: actual %b expected %b",
               req, nm, w, $time, act, exp);
    end
  endtask

  function automatic string ptag(string dflt);
    if (vlog_ok && !vbus_ok) return "R9";
    if (!vlog_ok) return "R10";
    return dflt;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic normal, e_le, e_ie, held, a, b, tdp, tdm, lvl;
      logic [1:0] s;
      s = hist[0];
      normal = vbus_ok && vlog_ok;
      e_le = normal && !m_oe && !m_gap;
      e_ie = normal && m_oe && !m_gap;
      held = (s == 2'b10) ? 1'b1 : (s == 2'b01) ? 1'b0 : m_last;
      for (int w = 0; w < 2; w++) begin
        if (w == 1) begin tdp = ifa_in; tdm = ifb_in; end
        else begin tdp = !ifb_in && ifa_in; tdm = !ifb_in && !ifa_in; end
        if (w == 1) begin a = s[1]; b = s[0]; end
        else begin a = susp_req ? s[1] : held; b = (s == 2'b00); end
        lvl = (w == 1) && !vbus_ok;
        chk(m_gap ? "R12" : ptag("R1"), "line_drv_en", w, lde[w], e_le);
        chk(m_gap ? "R12" : ptag("R1"), "if_drv_en", w, ide[w], e_ie);
        chk(w ? "R3" : "R2", "dp_out", w, dp_o[w], e_le & tdp);
        chk(w ? "R3" : "R2", "dm_out", w, dm_o[w], e_le & tdm);
        chk(w ? "R7" : "R6", "if_a_out", w, ia[w], e_ie ? a : lvl);
        chk(w ? "R7" : "R6", "if_b_out", w, ib[w], e_ie ? b : lvl);
        chk(susp_req ? "R5" : (w ? "R7" : "R4"), "rcv_out", w, rc[w],
            (w == 1) && normal && !susp_req && held);
        chk("R8", "pullup_on", w, pu[w], normal && enum_req);
        chk(ptag("R11"), "bus_det", w, bd[w], (w == 0) && normal);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line(logic p, logic m, int n);
    dp_in = p; dm_in = m;
    tick(n);
  endtask

  initial begin
    // Reset state (R4 idle J, held value 1; R1 receive direction)
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1/R2/R3: transmit patterns with direction turnaround (R12)
    oe_req = 1'b0; enum_req = 1'b1;
    tick(1);
    for (int k = 0; k < 4; k++) begin
      {ifa_in, ifb_in} = k[1:0];
      tick(2);
    end
    // R5: suspend keeps transmit alive
    susp_req = 1'b1; ifa_in = 1'b1; ifb_in = 1'b0;
    tick(3);
    susp_req = 1'b0;
    // R4/R6/R7: receive J, K, SE0 hold, SE1 hold
    oe_req = 1'b1;
    line(1, 0, 4); line(0, 0, 4); line(0, 1, 4); line(0, 0, 4);
    line(1, 1, 4); line(1, 0, 4);
    // R5/R6: suspend freezes the held value, DAT follows D+
    susp_req = 1'b1;
    line(0, 1, 4); line(0, 0, 4); line(1, 0, 4);
    susp_req = 1'b0;
    line(0, 0, 4);
    // R12: quick direction toggles
    oe_req = 1'b0; tick(1); oe_req = 1'b1; tick(1); oe_req = 1'b0; tick(3);
    // R9: sharing ignores oe and suspend
    vbus_ok = 1'b0;
    oe_req = 1'b1; tick(2); susp_req = 1'b1; oe_req = 1'b0; tick(3);
    susp_req = 1'b0;
    // R10: disabled and unpowered
    vbus_ok = 1'b1; vlog_ok = 1'b0; tick(3);
    vbus_ok = 1'b0; tick(3);
    vbus_ok = 1'b1; vlog_ok = 1'b1; tick(3);
    // R8: enumerate off
    enum_req = 1'b0; tick(2);
    // Mixed random stimulus over all inputs
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      dp_in = r[0]; dm_in = r[1]; ifa_in = r[2]; ifb_in = r[3];
      if (r[6:4] == 3'd0) oe_req = ~oe_req;
      if (r[9:7] == 3'd0) susp_req = ~susp_req;
      if (i % 97 == 0) enum_req = ~enum_req;
      if (i % 211 == 0) vbus_ok = ~vbus_ok;
      if (i % 331 == 0) vlog_ok = ~vlog_ok;
      if (i % 331 == 5) vlog_ok = 1'b1;
      tick(1);
    end
    // Mid-run reset returns to the idle state
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule